// File: doc/BRIEF.md
# Serpentine Full-Search SAD Matcher

This block finds the best integer motion vector for one current block inside a square search area. It keeps an N×N grid of processing elements, each holding one pixel of the current block. A matching N×N window of reference pixels sits on top of the grid. Every processing element forms the absolute difference between its two pixels. Each row chains these differences into a row sum, and a balanced adder tree combines the N row sums. The grid therefore yields the complete sum of absolute differences (SAD) for one candidate displacement in every cycle, and no partial sum is kept from one cycle to the next.

Candidates are visited in serpentine order over displacements from -P to +P on both axes. Along a row the window slides one column right or left, and at the end of a row it slides one row down. Each slide needs exactly one new line of N reference pixels. The block names that line on its edge request port, and the surrounding logic returns the line in the same cycle. Before a scan, a load phase streams in N rows of current pixels together with the N top rows of the initial window. A running minimum picks the best displacement as the SADs go by.

Top module: `snake_sad_array`

## Requirements
- R1: While reset is held and just after it, `sad_valid` and `best_valid` are low and `edge_dir` is 0 (no move).
- R2: Each cycle with `load_valid` high and no scan running shifts the current block and the window up by one row, taking `cur_row` and `ref_row` as the new bottom row, with pixel c at bits [c*PW +: PW] and c=0 leftmost. `start` is ignored until N such rows have been taken since reset or since the last scan.
- R3: Each reported `sad` equals the sum over all r and c of |cur[r][c] - area[dy+P+r][dx+P+c]|, where area is the (2P+N)-square search area with (0,0) at the top left. The first N loaded reference rows are area rows 0..N-1, columns 0..N-1.
- R4: After an accepted `start`, `sad_valid` is high for (2P+1)² consecutive cycles, starting on the second rising edge after `start` is sampled (one cycle of output register). The candidates are reported as signed (`sad_dx`, `sad_dy`) in serpentine order: dy runs from -P to +P, dx rises on even-indexed rows and falls on odd-indexed rows.
- R5: The edge request names the line needed for the next candidate. Code 1 asks for the column x=cx+N, code 2 for the column x=cx-1, both covering rows y..y+N-1 from `edge_y`=cy. Code 3 asks for the row y=cy+N, covering columns x..x+N-1 from `edge_x`=cx. Here (cx,cy) is the current window origin in area coordinates. `edge_pix` element i (bits [i*PW +: PW]) is the pixel at offset i along that line.
- R6: `best_valid` pulses together with the last SAD of a scan. `best_sad`, `best_dx` and `best_dy` then give the minimum SAD and its displacement. On equal SADs, the candidate earliest in scan order wins.
- R7: Once a scan has ended, `start` is ignored until the window has been reloaded with N rows.
- R8: `load_valid` and `start` have no effect while a scan is running: the SADs and the best result of that scan are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_valid | input | 1 | Shift in one load row |
| cur_row | input | N*PW | Current block row being loaded |
| ref_row | input | N*PW | Initial window row being loaded |
| start | input | 1 | Begin a scan when the window is full |
| edge_dir | output | 2 | Next window move: 0 none, 1 right, 2 left, 3 down |
| edge_x | output | CW | Area x of the first pixel of the requested line |
| edge_y | output | CW | Area y of the first pixel of the requested line |
| edge_pix | input | N*PW | Requested line of reference pixels, same cycle |
| sad_valid | output | 1 | SAD output is valid |
| sad | output | SW | SAD of the reported candidate |
| sad_dx | output | DW | Signed horizontal displacement |
| sad_dy | output | DW | Signed vertical displacement |
| best_valid | output | 1 | Scan finished, best result valid |
| best_sad | output | SW | Minimum SAD of the scan |
| best_dx | output | DW | Signed x of the best candidate |
| best_dy | output | DW | Signed y of the best candidate |

## Verification
The bench builds the block with N=4, P=2 and 8-bit pixels, which gives an 8×8 search area and 25 candidates per scan. A single scan then includes rightward, leftward and downward moves, with row turns at both side edges and every pixel of the area in use. Blocks filled with constant data produce all-equal SADs, which checks the tie rule. Saturated data produce the largest SAD of 4080 and so test the SAD width. A current block copied from inside the area checks that the tracker locks onto a unique zero.

// File: rtl/snake_sad_pkg.sv
package snake_sad_pkg;
  typedef enum logic [1:0] {
    MV_NONE  = 2'd0,
    MV_RIGHT = 2'd1,
    MV_LEFT  = 2'd2,
    MV_DOWN  = 2'd3
  } move_e;
endpackage

// File: rtl/snake_sched.sv
module snake_sched
  import snake_sad_pkg::*;
#(
  parameter int P  = 2,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_ok,
  output logic          scanning,
  output logic [CW-1:0] cx,
  output logic [CW-1:0] cy,
  output move_e         move,
  output logic          first,
  output logic          last
);
  localparam logic [CW-1:0] SPAN = CW'(2 * P);

  logic          scan_q, scan_d;
  logic [CW-1:0] cx_q, cx_d, cy_q, cy_d;

  always_comb begin
    last  = scan_q && (cy_q == SPAN) && (cx_q == SPAN);
    first = scan_q && (cx_q == '0) && (cy_q == '0);
    move  = MV_NONE;
    if (scan_q && !last) begin
      if (!cy_q[0]) move = (cx_q == SPAN) ? MV_DOWN : MV_RIGHT;
      else          move = (cx_q == '0)   ? MV_DOWN : MV_LEFT;
    end
  end

  always_comb begin
    scan_d = scan_q;
    cx_d   = cx_q;
    cy_d   = cy_q;
    if (!scan_q) begin
      if (start_ok) begin
        scan_d = 1'b1;
        cx_d   = '0;
        cy_d   = '0;
      end
    end else if (last) begin
      scan_d = 1'b0;
    end else begin
      case (move)
        MV_RIGHT: cx_d = cx_q + 1'b1;
        MV_LEFT:  cx_d = cx_q - 1'b1;
        MV_DOWN:  cy_d = cy_q + 1'b1;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_q <= 1'b0;
      cx_q   <= '0;
      cy_q   <= '0;
    end else begin
      scan_q <= scan_d;
      cx_q   <= cx_d;
      cy_q   <= cy_d;
    end
  end

  assign scanning = scan_q;
  assign cx       = cx_q;
  assign cy       = cy_q;
endmodule

// File: rtl/ref_window.sv
module ref_window
  import snake_sad_pkg::*;
#(
  parameter int N  = 4,
  parameter int PW = 8
) (
  input  logic              clk,
  input  logic              load_en,
  input  logic [N*PW-1:0]   cur_row,
  input  logic [N*PW-1:0]   ref_row,
  input  move_e             move,
  input  logic [N*PW-1:0]   edge_pix,
  output logic [N*N*PW-1:0] win_flat,
  output logic [N*N*PW-1:0] cur_flat
);
  logic [PW-1:0] win_q [N][N];
  logic [PW-1:0] win_d [N][N];
  logic [PW-1:0] cur_q [N][N];
  logic [PW-1:0] cur_d [N][N];

  always_comb begin
    win_d = win_q;
    cur_d = cur_q;
    if (load_en) begin
      for (int r = 0; r < N - 1; r++) begin
        for (int c = 0; c < N; c++) begin
          win_d[r][c] = win_q[r+1][c];
          cur_d[r][c] = cur_q[r+1][c];
        end
      end
      for (int c = 0; c < N; c++) begin
        win_d[N-1][c] = ref_row[c*PW +: PW];
        cur_d[N-1][c] = cur_row[c*PW +: PW];
      end
    end else begin
      case (move)
        MV_RIGHT: begin
          for (int r = 0; r < N; r++) begin
            for (int c = 0; c < N - 1; c++) win_d[r][c] = win_q[r][c+1];
            win_d[r][N-1] = edge_pix[r*PW +: PW];
          end
        end
        MV_LEFT: begin
          for (int r = 0; r < N; r++) begin
            for (int c = 1; c < N; c++) win_d[r][c] = win_q[r][c-1];
            win_d[r][0] = edge_pix[r*PW +: PW];
          end
        end
        MV_DOWN: begin
          for (int r = 0; r < N - 1; r++) begin
            for (int c = 0; c < N; c++) win_d[r][c] = win_q[r+1][c];
          end
          for (int c = 0; c < N; c++) win_d[N-1][c] = edge_pix[c*PW +: PW];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    win_q <= win_d;
    cur_q <= cur_d;
  end

  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      assign win_flat[(r*N+c)*PW +: PW] = win_q[r][c];
      assign cur_flat[(r*N+c)*PW +: PW] = cur_q[r][c];
    end
  end
endmodule

// File: rtl/sad_pe_array.sv
module sad_pe_array #(
  parameter int N  = 4,
  parameter int PW = 8,
  parameter int SW = 13
) (
  input  logic [N*N*PW-1:0] win_flat,
  input  logic [N*N*PW-1:0] cur_flat,
  output logic [SW-1:0]     sad
);
  localparam int LV = (N > 1) ? $clog2(N) : 1;
  localparam int NP = 1 << LV;

  logic [SW-1:0] row_sum [N];
  logic [SW-1:0] node [2*NP-1];

  for (genvar r = 0; r < N; r++) begin : g_row
    logic [SW-1:0] chain [N+1];
    assign chain[0] = '0;
    for (genvar c = 0; c < N; c++) begin : g_pe
      logic [PW-1:0] a, b, diff;
      assign a    = cur_flat[(r*N+c)*PW +: PW];
      assign b    = win_flat[(r*N+c)*PW +: PW];
      assign diff = (a > b) ? (a - b) : (b - a);
      assign chain[c+1] = chain[c] + SW'(diff);
    end
    assign row_sum[r] = chain[N];
  end

  for (genvar i = 0; i < NP; i++) begin : g_leaf
    if (i < N) begin : g_used
      assign node[NP-1+i] = row_sum[i];
    end else begin : g_pad
      assign node[NP-1+i] = '0;
    end
  end

  for (genvar k = 0; k < NP - 1; k++) begin : g_add
    assign node[k] = node[2*k+1] + node[2*k+2];
  end

  assign sad = node[0];
endmodule

// File: rtl/min_tracker.sv
module min_tracker #(
  parameter int SW = 13,
  parameter int DW = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 first,
  input  logic                 last,
  input  logic [SW-1:0]        sad_in,
  input  logic signed [DW-1:0] dx_in,
  input  logic signed [DW-1:0] dy_in,
  output logic [SW-1:0]        best_sad,
  output logic signed [DW-1:0] best_dx,
  output logic signed [DW-1:0] best_dy,
  output logic                 done
);
  logic [SW-1:0]        sad_q;
  logic signed [DW-1:0] dx_q, dy_q;
  logic                 done_q;
  logic                 take;

  assign take = en && (first || (sad_in < sad_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sad_q  <= '0;
      dx_q   <= '0;
      dy_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= en && last;
      if (take) begin
        sad_q <= sad_in;
        dx_q  <= dx_in;
        dy_q  <= dy_in;
      end
    end
  end

  assign best_sad = sad_q;
  assign best_dx  = dx_q;
  assign best_dy  = dy_q;
  assign done     = done_q;
endmodule

// File: rtl/snake_sad_array.sv
module snake_sad_array
  import snake_sad_pkg::*;
#(
  parameter int N  = 4,
  parameter int P  = 2,
  parameter int PW = 8,
  localparam int A  = 2 * P + N,
  localparam int CW = $clog2(A),
  localparam int DW = $clog2(P + 1) + 1,
  localparam int SW = PW + $clog2(N * N + 1),
  localparam int LW = $clog2(N + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_valid,
  input  logic [N*PW-1:0]      cur_row,
  input  logic [N*PW-1:0]      ref_row,
  input  logic                 start,
  output logic [1:0]           edge_dir,
  output logic [CW-1:0]        edge_x,
  output logic [CW-1:0]        edge_y,
  input  logic [N*PW-1:0]      edge_pix,
  output logic                 sad_valid,
  output logic [SW-1:0]        sad,
  output logic signed [DW-1:0] sad_dx,
  output logic signed [DW-1:0] sad_dy,
  output logic                 best_valid,
  output logic [SW-1:0]        best_sad,
  output logic signed [DW-1:0] best_dx,
  output logic signed [DW-1:0] best_dy
);
  logic [1:0] rst_sync;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  logic          scanning, first, last, armed, start_ok, load_en;
  logic [CW-1:0] cx, cy;
  move_e         move;
  logic [LW-1:0] lcnt_q, lcnt_d;

  assign armed    = (lcnt_q == LW'(N));
  assign start_ok = start && armed && !scanning;
  assign load_en  = load_valid && !scanning && !start_ok;

  always_comb begin
    lcnt_d = lcnt_q;
    if (scanning && last)             lcnt_d = '0;
    else if (load_en && !armed)       lcnt_d = lcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) lcnt_q <= '0;
    else          lcnt_q <= lcnt_d;
  end

  snake_sched #(.P(P), .CW(CW)) u_sched (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .start_ok (start_ok),
    .scanning (scanning),
    .cx       (cx),
    .cy       (cy),
    .move     (move),
    .first    (first),
    .last     (last)
  );

  logic [N*N*PW-1:0] win_flat, cur_flat;

  ref_window #(.N(N), .PW(PW)) u_win (
    .clk      (clk),
    .load_en  (load_en),
    .cur_row  (cur_row),
    .ref_row  (ref_row),
    .move     (move),
    .edge_pix (edge_pix),
    .win_flat (win_flat),
    .cur_flat (cur_flat)
  );

  logic [SW-1:0] sad_c;

  sad_pe_array #(.N(N), .PW(PW), .SW(SW)) u_pe (
    .win_flat (win_flat),
    .cur_flat (cur_flat),
    .sad      (sad_c)
  );

  always_comb begin
    edge_x = '0;
    edge_y = '0;
    case (move)
      MV_RIGHT: begin edge_x = cx + CW'(N); edge_y = cy;           end
      MV_LEFT:  begin edge_x = cx - 1'b1;   edge_y = cy;           end
      MV_DOWN:  begin edge_x = cx;          edge_y = cy + CW'(N);  end
      default:  ;
    endcase
  end
  assign edge_dir = move;

  logic signed [DW-1:0] cdx, cdy;
  assign cdx = DW'(int'(cx) - P);
  assign cdy = DW'(int'(cy) - P);

  min_tracker #(.SW(SW), .DW(DW)) u_min (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .en       (scanning),
    .first    (first),
    .last     (last),
    .sad_in   (sad_c),
    .dx_in    (cdx),
    .dy_in    (cdy),
    .best_sad (best_sad),
    .best_dx  (best_dx),
    .best_dy  (best_dy),
    .done     (best_valid)
  );

  logic                 vld_q;
  logic [SW-1:0]        sad_q;
  logic signed [DW-1:0] dx_q, dy_q;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      vld_q <= 1'b0;
      sad_q <= '0;
      dx_q  <= '0;
      dy_q  <= '0;
    end else begin
      vld_q <= scanning;
      if (scanning) begin
        sad_q <= sad_c;
        dx_q  <= cdx;
        dy_q  <= cdy;
      end
    end
  end

  assign sad_valid = vld_q;
  assign sad       = sad_q;
  assign sad_dx    = dx_q;
  assign sad_dy    = dy_q;
endmodule

// File: rtl/snake_sad_array_chk.sv
module snake_sad_array_chk #(
  parameter int P  = 2,
  parameter int CW = 3,
  parameter int DW = 3,
  parameter int SW = 13
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0]           edge_dir,
  input logic [CW-1:0]        edge_x,
  input logic                 sad_valid,
  input logic [SW-1:0]        sad,
  input logic signed [DW-1:0] sad_dx,
  input logic signed [DW-1:0] sad_dy,
  input logic                 best_valid,
  input logic [SW-1:0]        best_sad
);
  a_r4_run_unbroken: assert property (@(posedge clk) disable iff (!rst_n)
    sad_valid && !best_valid |=> sad_valid);

  a_r4_first_corner: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sad_valid) |-> (int'(sad_dx) == -P) && (int'(sad_dy) == -P));

  a_r4_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    sad_valid && $past(sad_valid) |->
      ((sad_dy == $past(sad_dy)) &&
       ((int'(sad_dx) - int'($past(sad_dx)) == 1) || (int'(sad_dx) - int'($past(sad_dx)) == -1))) ||
      ((sad_dx == $past(sad_dx)) && (int'(sad_dy) == int'($past(sad_dy)) + 1)));

  a_r6_best_with_last: assert property (@(posedge clk) disable iff (!rst_n)
    best_valid |-> sad_valid && (best_sad <= sad) && (int'(sad_dx) == P) && (int'(sad_dy) == P));

  a_r5_turn_at_side: assert property (@(posedge clk) disable iff (!rst_n)
    edge_dir == 2'd3 |-> (edge_x == '0) || (int'(edge_x) == 2 * P));

  a_r5_move_in_scan: assert property (@(posedge clk) disable iff (!rst_n)
    edge_dir != 2'd0 |=> sad_valid);
endmodule

bind snake_sad_array snake_sad_array_chk #(.P(P), .CW(CW), .DW(DW), .SW(SW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .edge_dir   (edge_dir),
  .edge_x     (edge_x),
  .sad_valid  (sad_valid),
  .sad        (sad),
  .sad_dx     (sad_dx),
  .sad_dy     (sad_dy),
  .best_valid (best_valid),
  .best_sad   (best_sad)
);

// File: tb/snake_sad_array_test.sv
`timescale 1ns/1ps
module snake_sad_array_test;
  localparam int N  = 4;
  localparam int P  = 2;
  localparam int PW = 8;
  localparam int A  = 2 * P + N;
  localparam int CW = $clog2(A);
  localparam int DW = $clog2(P + 1) + 1;
  localparam int SW = PW + $clog2(N * N + 1);
  localparam int S  = 2 * P + 1;
  localparam int C  = S * S;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 load_valid, start;
  logic [N*PW-1:0]      cur_row, ref_row, edge_pix;
  logic [1:0]           edge_dir;
  logic [CW-1:0]        edge_x, edge_y;
  logic                 sad_valid, best_valid;
  logic [SW-1:0]        sad, best_sad;
  logic signed [DW-1:0] sad_dx, sad_dy, best_dx, best_dy;

  logic [PW-1:0] cur_m  [N][N];
  logic [PW-1:0] area_m [A][A];

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  snake_sad_array #(.N(N), .P(P), .PW(PW)) uut (
    .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .cur_row(cur_row),
    .ref_row(ref_row), .start(start), .edge_dir(edge_dir), .edge_x(edge_x),
    .edge_y(edge_y), .edge_pix(edge_pix), .sad_valid(sad_valid), .sad(sad),
    .sad_dx(sad_dx), .sad_dy(sad_dy), .best_valid(best_valid),
    .best_sad(best_sad), .best_dx(best_dx), .best_dy(best_dy)
  );

  // Feeder for the R5 edge requests
  always_comb begin
    edge_pix = '0;
    for (int i = 0; i < N; i++) begin
      if (edge_dir == 2'd3) begin
        if (int'(edge_y) < A && int'(edge_x) + i < A)
          edge_pix[i*PW +: PW] = area_m[edge_y][int'(edge_x) + i];
      end else if (edge_dir != 2'd0) begin
        if (int'(edge_x) < A && int'(edge_y) + i < A)
          edge_pix[i*PW +: PW] = area_m[int'(edge_y) + i][edge_x];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_sad(input int cx, input int cy);
    int s = 0;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        int a = cur_m[r][c];
        int b = area_m[cy + r][cx + c];
        s += (a > b) ? a - b : b - a;
      end
    return s;
  endfunction

  function automatic int snake_x(input int k);
    int row = k / S;
    int col = k % S;
    return (row % 2 == 0) ? col : (S - 1 - col);
  endfunction

  task automatic fill(input int mode);
    int ox = $urandom_range(0, 2 * P);
    int oy = $urandom_range(0, 2 * P);
    int k  = $urandom_range(0, 255);
    for (int y = 0; y < A; y++)
      for (int x = 0; x < A; x++)
        case (mode)
          1: area_m[y][x] = PW'(k);
          3: area_m[y][x] = '0;
          default: area_m[y][x] = PW'($urandom_range(0, 255));
        endcase
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++)
        case (mode)
          2: cur_m[r][c] = area_m[oy + r][ox + c];
          3: cur_m[r][c] = '1;
          default: cur_m[r][c] = PW'($urandom_range(0, 255));
        endcase
  endtask

  task automatic load_rows(input int from, input int upto);
    for (int r = from; r < upto; r++) begin
      @(negedge clk);
      load_valid = 1'b1;
      for (int c = 0; c < N; c++) begin
        cur_row[c*PW +: PW] = cur_m[r][c];
        ref_row[c*PW +: PW] = area_m[r][c];
      end
    end
    @(negedge clk);
    load_valid = 1'b0;
  endtask

  // Pulse start and verify that nothing comes out (R2, R7)
  task automatic start_ignored(input string req);
    bit seen = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (4) begin
      @(negedge clk);
      if (sad_valid) seen = 1;
    end
    chk(!seen, req, seen, 0);
  endtask

  task automatic scan(input bit disturb);
    int bsad = 0, bx = 0, by = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < C; k++) begin
      int cx = snake_x(k);
      int cy = k / S;
      int es = exp_sad(cx, cy);
      if (k == 0 || es < bsad) begin bsad = es; bx = cx - P; by = cy - P; end
      if (disturb && k < C - 1) begin
        load_valid = 1'b1;
        start      = 1'b1;
        cur_row    = N*PW'($urandom());
        ref_row    = N*PW'($urandom());
      end else begin
        load_valid = 1'b0;
        start      = 1'b0;
      end
      @(negedge clk);
      chk(sad_valid && int'(sad_dx) == cx - P && int'(sad_dy) == cy - P,
          disturb ? "R8 R4 order" : "R4 order",
          (int'(sad_dx) + 8) * 16 + int'(sad_dy) + 8, (cx - P + 8) * 16 + cy - P + 8);
      chk(int'(sad) == es, disturb ? "R8 R3 sad" : "R3 sad", int'(sad), es);
      chk(best_valid == (k == C - 1), "R6 best_valid timing", best_valid, k == C - 1);
      if (k == C - 1) begin
        chk(int'(best_sad) == bsad, "R6 best_sad", int'(best_sad), bsad);
        chk(int'(best_dx) == bx && int'(best_dy) == by, "R6 best vector",
            int'(best_dx) * 16 + int'(best_dy), bx * 16 + by);
      end
    end
    load_valid = 1'b0;
    start      = 1'b0;
    @(negedge clk);
    chk(!sad_valid, "R4 run length", sad_valid, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; load_valid = 1'b0; start = 1'b0;
    cur_row = '0; ref_row = '0;
    repeat (3) @(negedge clk);
    chk(!sad_valid && !best_valid && edge_dir == 2'd0, "R1 reset outputs",
        {sad_valid, best_valid, edge_dir}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!sad_valid && !best_valid && edge_dir == 2'd0, "R1 after reset",
        {sad_valid, best_valid, edge_dir}, 0);

    start_ignored("R2 start with empty window");
    fill(0);
    load_rows(0, N - 1);
    start_ignored("R2 start with partial window");
    load_rows(N - 1, N);
    scan(1'b0);
    start_ignored("R7 start without reload");

    // directed: tie (all equal), saturated, embedded exact match
    fill(1); load_rows(0, N); scan(1'b0);
    fill(3); load_rows(0, N); scan(1'b0);
    fill(2); load_rows(0, N); scan(1'b0);
    // R8: disturbances during scan
    fill(0); load_rows(0, N); scan(1'b1);
    // random mix
    for (int t = 0; t < 6; t++) begin
      fill($urandom_range(0, 2));
      load_rows(0, N);
      scan(t[0]);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule